// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the SD card bus clock from a faster base clock. One 32-bit control word governs it. Software writes a 10-bit divide value, an internal clock enable and a card clock enable. The block then restarts a settle timer and reports a stable flag. The card clock reaches the output pin only when the card clock enable is set and the stable flag is high.

For a nonzero divide value N, the output has a period of 2·N base cycles with a 50% duty cycle. A divide value of zero passes the base clock straight through. The output is gated so that it never produces a runt pulse:

- A high phase that has already started always runs for its full length.
- The pass-through path switches only while the base clock is low.

A self-clearing soft reset bit returns every field to zero. The divided mode is the only mode the block has.

Top module: `sd_clk_gen`

## Requirements
- R1: After reset the control word reads 0x00000000 and `cardClk` is low.
- R2: The divide value is 10 bits wide. Its low 8 bits are written and read at control bits [15:8], and its top 2 bits at control bits [7:6].
- R3: With a divide value N of 1 or more and the output running, each `cardClk` period is 2·N base cycles: N cycles high, then N cycles low.
- R4: Stable (control bit 1) reads 0 from the edge that accepts a write that sets bit 0 while it was clear, or that changes the divide value. It reads 1 exactly STABLE_CYCLES base cycles later. It stays 0 while bit 0 is clear.
- R5: With a divide value of 0, the output running and the gate open, `cardClk` equals the base clock.
- R6: `cardClk` begins a high phase only while card enable (bit 2) and stable are both 1. While either is 0 it stays low, apart from finishing a high phase already in progress.
- R7: Clearing card enable during a high phase leaves that phase its full N cycles. The output then stays low.
- R8: Written values in bit 1, bit 5 and every unassigned bit have no effect. Bit 5 and the unassigned bits always read 0, and bit 1 reads only the stable state.
- R9: A write with bit 24 set clears the divide value and both enables. Bit 24 then reads 1 for SRST_CYCLES cycles, and writes during that window are ignored. After that it reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| baseClk | input | 1 | Base clock from which the card clock is derived |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control write strobe, one base cycle |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Current control word, including the stable flag |
| cardClk | output | 1 | Gated card bus clock |

## Verification
The hardest case to reach is stopping the output in the middle of a high phase. The disable write must land on the cycle right after a rising edge, or the no-runt rule goes untested. The bench watches `cardClk` at every falling base edge and issues the disable write at the same falling edge where it first sees the output high. It then counts how long that high phase lasts.

A second hard case is the hand-over to pass-through mode. The bench enters it from a running divided clock, so the bypass select must wait until the divided output and the gate are both idle. The output is then sampled on both halves of the base clock.

// File: rtl/sd_clk_gen_pkg.sv
package sd_clk_gen_pkg;
  localparam int REG_W      = 32;
  localparam int DIV_W      = 10;
  localparam int DIV_LO_W   = 8;
  localparam int DIV_HI_W   = DIV_W - DIV_LO_W;
  localparam int BIT_INT_EN = 0;
  localparam int BIT_STABLE = 1;
  localparam int BIT_CARD_EN = 2;
  localparam int DIV_HI_LSB = 6;
  localparam int DIV_LO_LSB = 8;
  localparam int BIT_SRST   = 24;

  // strobes from control to datapath
  typedef struct packed {
    logic             run;
    logic [DIV_W-1:0] divisor;
  } dpCtrl_t;
endpackage

// File: rtl/sd_clk_gen_ctrl.sv
module sd_clk_gen_ctrl
  import sd_clk_gen_pkg::*;
#(
  parameter int STABLE_CYCLES = 8,
  parameter int SRST_CYCLES   = 4
) (
  input  logic             baseClk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output dpCtrl_t          dpCtrl
);
  localparam int ST_W = $clog2(STABLE_CYCLES + 1);
  localparam int SR_W = $clog2(SRST_CYCLES + 1);
  localparam logic [ST_W-1:0] ST_LIMIT = ST_W'(STABLE_CYCLES);

  logic             intEn, cardEn, stable, restart, srstBusy;
  logic [DIV_W-1:0] divisor, newDiv;
  logic [ST_W-1:0]  stCnt;
  logic [SR_W-1:0]  srstCnt;

  assign newDiv   = {wrData[DIV_HI_LSB +: DIV_HI_W], wrData[DIV_LO_LSB +: DIV_LO_W]};
  assign srstBusy = (srstCnt != '0);
  assign restart  = wrEn && ((newDiv != divisor) || (wrData[BIT_INT_EN] && !intEn));
  assign stable   = intEn && (stCnt == ST_LIMIT);

  always_ff @(posedge baseClk or negedge rstN) begin
    if (!rstN) begin
      intEn   <= 1'b0;
      cardEn  <= 1'b0;
      divisor <= '0;
      stCnt   <= '0;
      srstCnt <= '0;
    end else if (srstBusy) begin
      intEn   <= 1'b0;
      cardEn  <= 1'b0;
      divisor <= '0;
      stCnt   <= '0;
      srstCnt <= srstCnt - SR_W'(1);
    end else if (wrEn && wrData[BIT_SRST]) begin
      intEn   <= 1'b0;
      cardEn  <= 1'b0;
      divisor <= '0;
      stCnt   <= '0;
      srstCnt <= SR_W'(SRST_CYCLES);
    end else begin
      if (wrEn) begin
        intEn   <= wrData[BIT_INT_EN];
        cardEn  <= wrData[BIT_CARD_EN];
        divisor <= newDiv;
      end
      if (restart || (wrEn && !wrData[BIT_INT_EN]) || !intEn)
        stCnt <= '0;
      else if (stCnt != ST_LIMIT)
        stCnt <= stCnt + ST_W'(1);
    end
  end

  always_comb begin
    rdData = '0;
    rdData[BIT_INT_EN]  = intEn;
    rdData[BIT_STABLE]  = stable;
    rdData[BIT_CARD_EN] = cardEn;
    rdData[DIV_HI_LSB +: DIV_HI_W] = divisor[DIV_W-1 -: DIV_HI_W];
    rdData[DIV_LO_LSB +: DIV_LO_W] = divisor[DIV_LO_W-1:0];
    rdData[BIT_SRST]    = srstBusy;
  end

  assign dpCtrl.run     = cardEn && stable;
  assign dpCtrl.divisor = divisor;
endmodule

// File: rtl/sd_clk_gen_dp.sv
module sd_clk_gen_dp
  import sd_clk_gen_pkg::*;
(
  input  logic    baseClk,
  input  logic    rstN,
  input  dpCtrl_t dpCtrl,
  output logic    cardClk
);
  logic [DIV_W-1:0] divCnt;
  logic             divClk, bypassSel, bypassGate, divZero, lastCount;

  assign divZero   = (dpCtrl.divisor == '0);
  assign lastCount = (divCnt >= dpCtrl.divisor - DIV_W'(1));

  // divided path: toggles every N base cycles, a started high phase always completes
  always_ff @(posedge baseClk or negedge rstN) begin
    if (!rstN) begin
      divClk <= 1'b0;
      divCnt <= '0;
    end else if (divZero) begin
      divClk <= 1'b0;
      divCnt <= '0;
    end else if (divClk) begin
      if (lastCount) begin
        divClk <= 1'b0;
        divCnt <= '0;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end else if (dpCtrl.run && !bypassSel) begin
      if (lastCount) begin
        divClk <= 1'b1;
        divCnt <= '0;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end else begin
      divCnt <= '0;
    end
  end

  // output select changes only while both paths are idle
  always_ff @(posedge baseClk or negedge rstN) begin
    if (!rstN)
      bypassSel <= 1'b1;
    else if (!bypassGate && !divClk && !dpCtrl.run)
      bypassSel <= divZero;
  end

  // pass-through gate moves only while the base clock is low
  always_ff @(negedge baseClk or negedge rstN) begin
    if (!rstN)
      bypassGate <= 1'b0;
    else
      bypassGate <= dpCtrl.run && bypassSel && divZero;
  end

  assign cardClk = bypassSel ? (baseClk & bypassGate) : divClk;
endmodule

// File: rtl/sd_clk_gen.sv
module sd_clk_gen
  import sd_clk_gen_pkg::*;
#(
  parameter int STABLE_CYCLES = 8,
  parameter int SRST_CYCLES   = 4
) (
  input  logic        baseClk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        cardClk
);
  dpCtrl_t dpCtrl;

  sd_clk_gen_ctrl #(
    .STABLE_CYCLES(STABLE_CYCLES),
    .SRST_CYCLES  (SRST_CYCLES)
  ) i_ctrl (
    .baseClk(baseClk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .dpCtrl (dpCtrl)
  );

  sd_clk_gen_dp i_dp (
    .baseClk(baseClk),
    .rstN   (rstN),
    .dpCtrl (dpCtrl),
    .cardClk(cardClk)
  );
endmodule

// File: rtl/sd_clk_gen_chk.sv
module sd_clk_gen_chk (
  input logic        baseClk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        cardClk
);
  assert_stable_needs_int_R4: assert property (@(posedge baseClk) disable iff (!rstN)
    rdData[1] |-> rdData[0]);

  assert_div_change_drops_stable_R4: assert property (@(posedge baseClk) disable iff (!rstN)
    (wrEn && !wrData[24] && !rdData[24] &&
     ({wrData[7:6], wrData[15:8]} != {rdData[7:6], rdData[15:8]})) |=> !rdData[1]);

  assert_srst_clears_R9: assert property (@(posedge baseClk) disable iff (!rstN)
    (wrEn && wrData[24] && !rdData[24]) |=> (rdData[24] && rdData[15:0] == 16'h0));

  assert_rise_only_running_R6: assert property (@(posedge baseClk) disable iff (!rstN)
    $rose(cardClk) |-> $past(rdData[2] && rdData[1]));

  assert_reserved_zero_R8: assert property (@(posedge baseClk) disable iff (!rstN)
    (wrEn && !rdData[24]) |=> (rdData[5:3] == 3'b0 && rdData[31:25] == 7'b0));
endmodule

bind sd_clk_gen sd_clk_gen_chk i_chk (
  .baseClk(baseClk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData),
  .cardClk(cardClk)
);

// File: tb/test_sd_clk_gen.sv
`timescale 1ns/1ps
module test_sd_clk_gen;
  localparam int L = 8;
  localparam int SR = 4;

  logic        baseClk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cardClk;

  int vecCnt = 0;
  int errCnt = 0;
  bit finished = 0;

  int  expQ[$];
  bit  monEn = 0;
  logic prevS;
  int  runLen, hiLen;
  bit  seenRise, seenFall;

  always #2.5 baseClk = ~baseClk;

  sd_clk_gen #(.STABLE_CYCLES(L), .SRST_CYCLES(SR)) i_sd_clk_gen (
    .baseClk(baseClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cardClk(cardClk));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [31:0] d);
    @(negedge baseClk);
    wrEn = 1'b1; wrData = d;
    @(negedge baseClk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // scoreboard driver: expect k full periods of divide value n
  task automatic expectPeriods(input int n, input int k);
    for (int i = 0; i < k; i++) expQ.push_back(n);
    monEn = 1;
    for (int g = 0; g < 20000 && expQ.size() > 0; g++) @(negedge baseClk);
    if (expQ.size() > 0) begin
      vecCnt++; errCnt++;
      $display("FAIL R3 actual=%0d_periods_missing expected=0", expQ.size());
      expQ.delete();
    end
    monEn = 0;
  endtask

  // scoreboard monitor: measures high and low run lengths at falling base edges
  always @(negedge baseClk) begin
    if (!monEn) begin
      prevS = cardClk; runLen = 0; seenRise = 0; seenFall = 0;
    end else if (cardClk !== prevS) begin
      if (cardClk === 1'b1) begin
        if (seenRise && seenFall && expQ.size() > 0) begin
          int e;
          e = expQ.pop_front();
          chk("R3_high", hiLen, e);
          chk("R3_low", runLen, e);
        end
        seenRise = 1; seenFall = 0;
      end else begin
        hiLen = runLen;
        seenFall = seenRise;
      end
      runLen = 1;
      prevS = cardClk;
    end else begin
      runLen++;
    end
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    int hiCount;
    repeat (3) @(negedge baseClk);
    rstN = 1'b1;
    @(negedge baseClk);
    chk("R1_word", rdData, 32'h0);
    chk("R1_clk", {31'b0, cardClk}, 32'h0);

    // R8: stable and mode bits are not writable
    writeReg(32'h0000_0022);
    chk("R8", rdData, 32'h0);

    // R2/R4: divide 3, internal enable
    writeReg(32'h0000_0301);
    chk("R2_lo", rdData, 32'h0000_0301);
    repeat (L - 1) @(negedge baseClk);
    chk("R4_early", {31'b0, rdData[1]}, 32'h0);
    @(negedge baseClk);
    chk("R4_on", {31'b0, rdData[1]}, 32'h1);

    // R6: card enable clear keeps output low
    hiCount = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge baseClk);
      if (cardClk) hiCount++;
    end
    chk("R6_gated", hiCount, 0);

    // R3: same divisor, enable card clock, stable must remain
    writeReg(32'h0000_0305);
    chk("R4_keep", {31'b0, rdData[1]}, 32'h1);
    expectPeriods(3, 3);

    // R2/R4: divide 257 uses upper field
    writeReg(32'h0000_0145);
    chk("R4_drop", {31'b0, rdData[1]}, 32'h0);
    chk("R2_hi", {16'b0, rdData[15:0]}, 32'h0000_0145);
    expectPeriods(257, 2);

    writeReg(32'h0000_0105);
    expectPeriods(1, 4);

    // R7: disable during a high phase
    writeReg(32'h0000_0405);
    repeat (L + 2) @(negedge baseClk);
    for (int g = 0; g < 100 && !cardClk; g++) @(negedge baseClk);
    wrEn = 1'b1; wrData = 32'h0000_0401;
    hiCount = 1;
    @(negedge baseClk);
    wrEn = 1'b0; wrData = '0;
    for (int i = 0; i < 30; i++) begin
      if (cardClk) hiCount++;
      @(negedge baseClk);
    end
    chk("R7_full_high", hiCount, 4);
    chk("R7_low_after", {31'b0, cardClk}, 32'h0);

    // R5: pass-through with divide 0
    writeReg(32'h0000_0005);
    repeat (L + 3) @(negedge baseClk);
    for (int i = 0; i < 3; i++) begin
      @(posedge baseClk); #1;
      chk("R5_high", {31'b0, cardClk}, 32'h1);
      @(negedge baseClk); #1;
      chk("R5_low", {31'b0, cardClk}, 32'h0);
    end
    writeReg(32'h0000_0001);
    @(negedge baseClk);
    hiCount = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge baseClk); #1;
      if (cardClk) hiCount++;
    end
    chk("R6_bypass_gated", hiCount, 0);

    // R9: soft reset
    writeReg(32'h0000_0305);
    repeat (L + 2) @(negedge baseClk);
    writeReg(32'h0100_0000);
    chk("R9_busy", rdData, 32'h0100_0000);
    writeReg(32'h0000_0305);
    repeat (SR) @(negedge baseClk);
    chk("R9_clear", rdData, 32'h0);
    chk("R9_clk", {31'b0, cardClk}, 32'h0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule